// File: doc/BRIEF.md
# Video timing reference decoder

This block sits on a 10-bit parallel digital video stream that delivers one word per clock. It recovers the line and field timing from the stream. It looks for timing reference sequences in two framings. The first is the component framing, with start and end of active video words. The second is the composite framing, where a reference is followed by an identification word. From these it drives a horizontal sync, a vertical blanking flag and a three-bit field number.

The block also tracks ancillary packets. It flags every word of a packet from the first header word through the checksum, using the data count word to find the end. An optional mode extends that flag over the timing reference words themselves. A loss-of-reference flag watches how often references arrive. It sets after seven line windows in a row pass without one, and it clears after seven references arrive with no empty window between them.

A single parser state machine classifies the words. Its states are named below:
- `ST_HUNT`: idle.
- `ST_ONE`: after an all-ones word.
- `ST_Z1`, `ST_Z2`, `ST_Z3`: after one, two or three all-zero words following it.
- `ST_AZ` and `ST_AF1`: partial component packet header.
- `ST_DID`, `ST_BLK`, `ST_DC`, `ST_DATA`, `ST_CS`: the packet body.

Its transitions are named below:
- "open" (`ST_HUNT` to `ST_ONE` on 3FF).
- "zero run" (`ST_ONE`→`ST_Z1`→`ST_Z2`, and `ST_Z2`→`ST_Z3` in composite mode).
- "reference" (`ST_Z2` in component mode, or `ST_Z3`, back to `ST_HUNT`).
- "header lead" (`ST_HUNT`/`ST_AZ` to `ST_AZ` on 000, then `ST_AZ`→`ST_AF1` on 3FF).
- "header" (`ST_AF1`→`ST_DID` on 3FF, or `ST_HUNT`→`ST_DID` on 3FC in composite mode).
- "body walk" (`ST_DID`→`ST_BLK`→`ST_DC`, then `ST_DC`→`ST_DATA` or, on a zero count, `ST_DC`→`ST_CS`).
- "count down" (`ST_DATA` stays until its count reaches one, then goes to `ST_CS`).
- "close" (`ST_CS`→`ST_HUNT`).
- "restart": on any unexpected word, the word is judged again as if in `ST_HUNT`.

Top module: `vid_timing_decoder`

## Requirements
- R1: After reset: `hsync`, `vblank`, `anc_flag` are 0, `field_id` is 0 and `no_ref` is 1.
- R2: With `composite`=0, the sequence 3FF,000,000,XYZ is a reference if bit 9 of XYZ is 1. Its outputs take effect in the cycle after XYZ is sampled. `field_id` becomes {0,0,XYZ bit 8}.
- R3: In component mode, `hsync` goes to 1 on a reference with XYZ bit 6 = 1 (end of active video). It goes to 0 on a reference with bit 6 = 0 (start of active video). It holds its value between references.
- R4: In component mode, `vblank` takes XYZ bit 7 on each reference and changes at no other time.
- R5: With `composite`=1, the sequence 3FF,000,000,000,ID is a reference. `field_id` takes ID bits 2:0 and `vblank` takes ID bit 3. `hsync` is 1 for exactly the one cycle after ID is sampled.
- R6: The component ancillary header is 000,3FF,3FF. It is followed by a data ID word, a block number word, a data count word (count in bits 7:0), that many data words and a checksum word. `anc_flag` is 1 for every one of these words and 0 around them. The flag for the word sampled at edge E appears after edge E+4.
- R7: In composite mode, a single 3FC word is the ancillary header. It is followed by the same body as in R6, with the same flag span and latency.
- R8: A data count of zero makes the checksum the word right after the count word. `anc_flag` falls after it.
- R9: With `mark_trs`=1, the words of a reference also raise `anc_flag`: 4 words in component mode and 5 in composite mode. With `mark_trs`=0 they do not.
- R10: A window passes with no reference after `LINE_LEN`+`MARGIN` cycles. Seven such windows in a row set `no_ref`, in the cycle after the seventh window closes. Six windows leave it unchanged.
- R11: Seven references with no empty window between them clear `no_ref`, in the cycle after the seventh. Six references leave it set.
- R12: Words inside an ancillary packet body are never taken as references, even when they spell one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 10 | Video word |
| composite | input | 1 | 1 selects composite framing, 0 selects component |
| mark_trs | input | 1 | 1 also flags reference words on `anc_flag` |
| hsync | output | 1 | Horizontal sync |
| vblank | output | 1 | Vertical blanking |
| field_id | output | 3 | Field number |
| anc_flag | output | 1 | Ancillary packet (or marked reference) word, four cycles late |
| no_ref | output | 1 | Stream has lost its timing references |

## Verification
The composite reference is the place where two functions meet at one edge. When the identification word is sampled with `mark_trs` set, the sync pulse and the retroactive marking of all five reference words happen on the same edge. The bench therefore drives composite references with marking on and off. It checks the one-cycle `hsync` pulse at the edge of the identification word. It checks `anc_flag` four cycles after each of the five words. The flag must be high for all five words when marking is on, and low when it is off.

// File: rtl/vtd_pkg.sv
package vtd_pkg;

    typedef enum logic [3:0] {
        ST_HUNT,
        ST_ONE,
        ST_Z1,
        ST_Z2,
        ST_Z3,
        ST_AZ,
        ST_AF1,
        ST_DID,
        ST_BLK,
        ST_DC,
        ST_DATA,
        ST_CS
    } vtd_state_e;

    localparam int COMP_TRS_LEN = 4;
    localparam int CMPS_TRS_LEN = 5;
    localparam int COMP_HDR_LEN = 3;
    localparam int CMPS_HDR_LEN = 1;
    localparam int ANC_LAT      = CMPS_TRS_LEN - 1;

endpackage

// File: rtl/vtd_parser.sv
module vtd_parser
    import vtd_pkg::*;
#(
    parameter int DW = 10,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  logic          composite,
    output vtd_state_e    state_q,
    output logic          trs_done,
    output logic          hdr_done,
    output logic          in_body
);

    localparam logic [DW-1:0] W_ONES = {DW{1'b1}};
    localparam logic [DW-1:0] W_ZERO = {DW{1'b0}};
    localparam logic [DW-1:0] W_CHDR = W_ONES - DW'(3);

    vtd_state_e    nxt;
    logic [CW-1:0] cnt_q, cnt_d;

    function automatic vtd_state_e hunt_next(input logic [DW-1:0] w, input logic cmp);
        if (w == W_ONES)                 return ST_ONE;
        else if (cmp && w == W_CHDR)     return ST_DID;
        else if (!cmp && w == W_ZERO)    return ST_AZ;
        else                             return ST_HUNT;
    endfunction

    assign in_body  = (state_q == ST_DID) || (state_q == ST_BLK) || (state_q == ST_DC)
                   || (state_q == ST_DATA) || (state_q == ST_CS);
    assign trs_done = (state_q == ST_Z3 && composite)
                   || (state_q == ST_Z2 && !composite && din[DW-1]);
    assign hdr_done = (nxt == ST_DID) && !in_body;

    always_comb begin
        nxt   = state_q;
        cnt_d = cnt_q;
        unique case (state_q)
            ST_HUNT: nxt = hunt_next(din, composite);
            ST_ONE:  nxt = (din == W_ZERO) ? ST_Z1 : hunt_next(din, composite);
            ST_Z1:   nxt = (din == W_ZERO) ? ST_Z2 : hunt_next(din, composite);
            ST_Z2: begin
                if (composite)
                    nxt = (din == W_ZERO) ? ST_Z3 : hunt_next(din, composite);
                else if (din[DW-1])
                    nxt = ST_HUNT;
                else
                    nxt = hunt_next(din, composite);
            end
            ST_Z3:   nxt = ST_HUNT;
            ST_AZ: begin
                if (din == W_ONES)      nxt = ST_AF1;
                else if (din == W_ZERO) nxt = ST_AZ;
                else                    nxt = hunt_next(din, composite);
            end
            ST_AF1: begin
                if (din == W_ONES)      nxt = ST_DID;
                else if (din == W_ZERO) nxt = ST_Z1;
                else                    nxt = hunt_next(din, composite);
            end
            ST_DID:  nxt = ST_BLK;
            ST_BLK:  nxt = ST_DC;
            ST_DC: begin
                cnt_d = din[CW-1:0];
                nxt   = (din[CW-1:0] == '0) ? ST_CS : ST_DATA;
            end
            ST_DATA: begin
                cnt_d = cnt_q - 1'b1;
                nxt   = (cnt_q <= CW'(1)) ? ST_CS : ST_DATA;
            end
            ST_CS:   nxt = ST_HUNT;
            default: nxt = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= nxt;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/vtd_ancmark.sv
module vtd_ancmark
    import vtd_pkg::*;
#(
    parameter int TAPS = ANC_LAT + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_body,
    input  logic hdr_done,
    input  logic trs_done,
    input  logic composite,
    input  logic mark_trs,
    output logic anc_flag
);

    function automatic logic [TAPS-1:0] low_ones(input int n);
        logic [TAPS-1:0] m;
        m = '0;
        for (int i = 0; i < TAPS; i++)
            if (i < n) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [TAPS-1:0] M_CHDR = low_ones(COMP_HDR_LEN);
    localparam logic [TAPS-1:0] M_PHDR = low_ones(CMPS_HDR_LEN);
    localparam logic [TAPS-1:0] M_CTRS = low_ones(COMP_TRS_LEN);
    localparam logic [TAPS-1:0] M_PTRS = low_ones(CMPS_TRS_LEN);

    logic [TAPS-1:0] sr_q, sr_d, hdr_m, trs_m;

    always_comb begin
        hdr_m = hdr_done ? (composite ? M_PHDR : M_CHDR) : '0;
        trs_m = (trs_done && mark_trs) ? (composite ? M_PTRS : M_CTRS) : '0;
        sr_d  = {sr_q[TAPS-2:0], in_body} | hdr_m | trs_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign anc_flag = sr_q[TAPS-1];

endmodule

// File: rtl/vtd_refwatch.sv
module vtd_refwatch #(
    parameter int WIN = 1780,
    parameter int RUN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_hit,
    output logic miss_pulse,
    output logic no_ref
);

    localparam int GW = $clog2(WIN + 1);
    localparam int RW = $clog2(RUN + 1);

    logic [GW-1:0] gap_q;
    logic [RW-1:0] miss_q, hit_q;

    assign miss_pulse = !ref_hit && (gap_q == GW'(WIN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            miss_q <= '0;
            hit_q  <= '0;
            no_ref <= 1'b1;
        end else if (ref_hit) begin
            gap_q  <= '0;
            miss_q <= '0;
            if (hit_q != RW'(RUN)) hit_q <= hit_q + 1'b1;
            if (hit_q == RW'(RUN - 1)) no_ref <= 1'b0;
        end else if (miss_pulse) begin
            gap_q <= '0;
            hit_q <= '0;
            if (miss_q != RW'(RUN)) miss_q <= miss_q + 1'b1;
            if (miss_q == RW'(RUN - 1)) no_ref <= 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

endmodule

// File: rtl/vid_timing_decoder.sv
module vid_timing_decoder
    import vtd_pkg::*;
#(
    parameter int DW       = 10,
    parameter int CW       = 8,
    parameter int LINE_LEN = 1716,
    parameter int MARGIN   = 64,
    parameter int RUN      = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    input  logic          composite,
    input  logic          mark_trs,
    output logic          hsync,
    output logic          vblank,
    output logic [2:0]    field_id,
    output logic          anc_flag,
    output logic          no_ref
);

    localparam int WIN   = LINE_LEN + MARGIN;
    localparam int F_BIT = DW - 2;
    localparam int V_BIT = DW - 3;
    localparam int H_BIT = DW - 4;
    localparam int IDVB  = 3;

    vtd_state_e state_q;
    logic       trs_done, hdr_done, in_body, miss_pulse;

    vtd_parser #(.DW(DW), .CW(CW)) u_parser (
        .clk(clk), .rst_n(rst_n), .din(din), .composite(composite),
        .state_q(state_q), .trs_done(trs_done), .hdr_done(hdr_done), .in_body(in_body)
    );

    vtd_ancmark u_mark (
        .clk(clk), .rst_n(rst_n), .in_body(in_body), .hdr_done(hdr_done),
        .trs_done(trs_done), .composite(composite), .mark_trs(mark_trs),
        .anc_flag(anc_flag)
    );

    vtd_refwatch #(.WIN(WIN), .RUN(RUN)) u_watch (
        .clk(clk), .rst_n(rst_n), .ref_hit(trs_done),
        .miss_pulse(miss_pulse), .no_ref(no_ref)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hsync    <= 1'b0;
            vblank   <= 1'b0;
            field_id <= '0;
        end else if (trs_done) begin
            if (composite) begin
                hsync    <= 1'b1;
                vblank   <= din[IDVB];
                field_id <= din[2:0];
            end else begin
                hsync    <= din[H_BIT];
                vblank   <= din[V_BIT];
                field_id <= {2'b00, din[F_BIT]};
            end
        end else if (composite) begin
            hsync <= 1'b0;
        end
    end

endmodule

// File: rtl/vtd_checker.sv
module vtd_checker
    import vtd_pkg::*;
#(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          composite,
    input logic          hsync,
    input logic          vblank,
    input logic          no_ref,
    input vtd_state_e    state_q,
    input logic [CW-1:0] dc_word,
    input logic          trs_done,
    input logic          miss_pulse
);

    logic body_now;
    assign body_now = (state_q == ST_DID) || (state_q == ST_BLK) || (state_q == ST_DC)
                   || (state_q == ST_DATA) || (state_q == ST_CS);

    AST_COMP_HS_AT_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(hsync) && !$past(composite)) |-> $past(trs_done)); // R3

    AST_VB_AT_REF: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vblank) |-> $past(trs_done)); // R4

    AST_CMPS_HS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (composite && $past(composite) && $past(hsync)) |-> !hsync); // R5

    AST_DC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DC && dc_word == '0) |=> state_q == ST_CS); // R8

    AST_NOREF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_ref) |-> $past(miss_pulse)); // R10

    AST_NOREF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(no_ref) |-> $past(trs_done)); // R11

    AST_BODY_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        body_now |=> $stable(hsync)); // R12

endmodule

bind vid_timing_decoder vtd_checker #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .composite(composite), .hsync(hsync),
    .vblank(vblank), .no_ref(no_ref), .state_q(state_q),
    .dc_word(din[CW-1:0]), .trs_done(trs_done), .miss_pulse(miss_pulse)
);

// File: tb/tb_vid_timing_decoder.sv
`timescale 1ns/1ps
module tb_vid_timing_decoder;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] din;
    logic       composite, mark_trs;
    logic       hsync, vblank, anc_flag, no_ref;
    logic [2:0] field_id;

    always #4 clk = ~clk;

    vid_timing_decoder #(.LINE_LEN(40), .MARGIN(8)) dut (
        .clk(clk), .rst_n(rst_n), .din(din), .composite(composite),
        .mark_trs(mark_trs), .hsync(hsync), .vblank(vblank),
        .field_id(field_id), .anc_flag(anc_flag), .no_ref(no_ref)
    );

    typedef struct { int due; int sig; int expv; string tag; } item_t;
    item_t sb[$];
    int    cyc = 0, n_chk = 0, n_fail = 0, last_e = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sample(input int sig);
        case (sig)
            0: return int'(hsync);
            1: return int'(vblank);
            2: return int'(field_id);
            3: return int'(anc_flag);
            default: return int'(no_ref);
        endcase
    endfunction

    task automatic judge(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic push(input int due, input int sig, input int expv, input string tag);
        item_t it;
        it.due = due; it.sig = sig; it.expv = expv; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: pops every expected item due at this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                judge(sb[i].tag, sample(sb[i].sig), sb[i].expv);
                sb.delete(i);
            end
        end
    end

    task automatic send(input logic [9:0] w, input int anc, input string tag);
        @(negedge clk);
        din    = w;
        last_e = cyc + 1;
        push(last_e + 4, 3, anc, tag);
    endtask

    task automatic fill(input int n, input string tag);
        for (int i = 0; i < n; i++) send(10'h200, 0, tag);
    endtask

    task automatic trs_comp(input logic [9:0] xyz, input int anc);
        send(10'h3FF, anc, "R9 component ref word marking");
        send(10'h000, anc, "R9 component ref word marking");
        send(10'h000, anc, "R9 component ref word marking");
        send(xyz,     anc, "R9 component ref word marking");
    endtask

    task automatic trs_cmps(input logic [9:0] id, input int anc);
        send(10'h3FF, anc, "R9 composite ref word marking");
        for (int i = 0; i < 3; i++) send(10'h000, anc, "R9 composite ref word marking");
        send(id, anc, "R9 composite ref word marking");
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired (all requirements) actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int r;
        rst_n = 1'b0; din = 10'h200; composite = 1'b0; mark_trs = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        judge("R1 reset hsync", int'(hsync), 0);
        judge("R1 reset vblank", int'(vblank), 0);
        judge("R1 reset field_id", int'(field_id), 0);
        judge("R1 reset anc_flag", int'(anc_flag), 0);
        judge("R1 reset no_ref", int'(no_ref), 1);

        // R11: seven component references clear the loss flag
        for (int i = 1; i <= 7; i++) begin
            fill(10, "R6 anc low between packets");
            trs_comp(10'h2C0, 0);
            push(last_e, 4, (i < 7) ? 1 : 0, "R11 no_ref after ref run");
            if (i == 1) begin
                push(last_e, 0, 1, "R3 hsync high at end of active video");
                push(last_e, 1, 1, "R4 vblank follows V");
                push(last_e, 2, 0, "R2 field follows F");
            end
        end

        // R6: component ancillary packet, three data words
        fill(3, "R6 anc low before packet");
        send(10'h000, 1, "R6 header word"); send(10'h3FF, 1, "R6 header word");
        send(10'h3FF, 1, "R6 header word"); send(10'h041, 1, "R6 data id");
        send(10'h001, 1, "R6 block number"); send(10'h003, 1, "R6 data count");
        send(10'h100, 1, "R6 data word"); send(10'h155, 1, "R6 data word");
        send(10'h2AA, 1, "R6 data word"); send(10'h1AB, 1, "R6 checksum");
        fill(5, "R6 anc low after checksum");

        trs_comp(10'h300, 0);
        push(last_e, 0, 0, "R3 hsync low at start of active video");
        push(last_e, 1, 0, "R4 vblank follows V");
        push(last_e, 2, 1, "R2 field follows F");

        // R12: packet body spelling a reference
        fill(3, "R6 anc low before packet");
        send(10'h000, 1, "R12 header"); send(10'h3FF, 1, "R12 header");
        send(10'h3FF, 1, "R12 header"); send(10'h050, 1, "R12 data id");
        send(10'h001, 1, "R12 block"); send(10'h004, 1, "R12 count");
        send(10'h3FF, 1, "R12 body"); send(10'h000, 1, "R12 body");
        send(10'h000, 1, "R12 body"); send(10'h2C0, 1, "R12 body");
        push(last_e, 0, 0, "R12 body not taken as reference (hsync)");
        push(last_e, 1, 0, "R12 body not taken as reference (vblank)");
        send(10'h1AB, 1, "R12 checksum");
        fill(3, "R12 anc low after packet");

        // R9: marking on, component
        mark_trs = 1'b1;
        trs_comp(10'h2C0, 1);
        fill(3, "R9 anc low after marked ref");

        // R5: composite references with marking on
        composite = 1'b1;
        fill(3, "R9 anc low before composite ref");
        trs_cmps(10'h205, 1);
        push(last_e, 0, 1, "R5 hsync pulse on composite ref");
        push(last_e, 2, 5, "R5 field from ID");
        push(last_e, 1, 0, "R5 vblank from ID");
        send(10'h200, 0, "R9 anc low after composite ref");
        push(last_e, 0, 0, "R5 hsync pulse lasts one cycle");
        fill(2, "R9 anc low after composite ref");
        trs_cmps(10'h20B, 1);
        push(last_e, 2, 3, "R5 field from ID");
        push(last_e, 1, 1, "R5 vblank from ID");
        fill(3, "R9 anc low after composite ref");

        // R7/R8: composite packets
        mark_trs = 1'b0;
        send(10'h3FC, 1, "R7 composite header"); send(10'h041, 1, "R7 data id");
        send(10'h001, 1, "R7 block"); send(10'h002, 1, "R7 count");
        send(10'h010, 1, "R7 data"); send(10'h020, 1, "R7 data");
        send(10'h1AB, 1, "R7 checksum");
        fill(3, "R7 anc low after packet");
        send(10'h3FC, 1, "R8 header"); send(10'h042, 1, "R8 data id");
        send(10'h001, 1, "R8 block"); send(10'h000, 1, "R8 zero count");
        send(10'h1AC, 1, "R8 checksum right after count");
        send(10'h200, 0, "R8 anc falls after checksum");
        fill(2, "R8 anc low");

        // R10: references stop
        trs_cmps(10'h201, 0);
        r = last_e;
        push(last_e, 4, 0, "R11 no_ref stays clear");
        while (last_e < r + 340) begin
            send(10'h200, 0, "R10 anc low while idle");
            if (last_e == r + 300) push(last_e, 4, 0, "R10 six empty windows");
            if (last_e == r + 335) push(last_e, 4, 0, "R10 before seventh window closes");
            if (last_e == r + 336) push(last_e, 4, 1, "R10 set after seven empty windows");
        end
        repeat (8) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule